// File: doc/BRIEF.md
# Selectable System Clock Prescaler

This block turns a free-running oscillator clock into a pair of clock-enable strobes, one for the system domain and one for the timer domain. No clock is gated or derived: logic elsewhere runs on the oscillator clock and advances only in cycles where the strobe is high. Two optional divide stages set the strobe rate. The first is a halving stage that can be skipped. The second is a further divide-by-16 that can be switched in. This gives overall ratios of 1, 2, 16 or 32 oscillator cycles per strobe.

Both stage selects sit in one control register, reached through a plain address/bank register port. A full reset puts the block in halving mode with the extra divider off. A stop-mode recovery pulse turns the extra divider off and leaves the halving select as it was. A changed setting never cuts a division period short. It is adopted at the terminal count of the period in progress, so every strobe gap is a whole period of either the old or the new ratio.

Top module: `sclk_prescaler`

## Requirements
- R1: After a full reset (active-low `rst_n`, asynchronous) both selects are 0, no strobe is high while reset is held, and strobes then arrive every 2 oscillator cycles.
- R2: With the halving-skip select (control bit 1) set and the extra divider (bit 0) clear, a strobe is high in every oscillator cycle.
- R3: With bit 0 set, the strobe period is multiplied by 16: 16 cycles when bit 1 is set, 32 cycles when bit 1 is clear.
- R4: A new setting is adopted only at the terminal count of the current period. A period already in progress completes at its old length. A write accepted in the terminal-count cycle governs the very next period.
- R5: A one-cycle `stop_rcv` pulse clears bit 0 and keeps bit 1. It takes effect at the next terminal count, like a write. If it coincides with a write, bit 0 ends up clear.
- R6: A read with `reg_bank` = 0xF and `reg_addr` = 0x0B returns `stat_in` on bit 7 and 0 on bits 6..0, in the same cycle. Any other address reads as all zeros.
- R7: A write (`reg_wr` high) changes the control bits only when `reg_bank` = 0xF and `reg_addr` = 0x0B. Writes to any other bank or address leave the strobe rate unchanged.
- R8: `tclk_en` is identical to `sclk_en` in every cycle, and each strobe is high for one oscillator cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Full reset, active low, asynchronous |
| stop_rcv | input | 1 | One-cycle stop-mode recovery pulse |
| reg_bank | input | 4 | Register bank select |
| reg_addr | input | 8 | Register address within the bank |
| reg_wr | input | 1 | Write request for the current cycle |
| reg_wdata | input | 8 | Write data (bit 1 skips halving, bit 0 adds divide-by-16) |
| stat_in | input | 1 | Status flag returned on read bit 7 |
| reg_rdata | output | 8 | Read data, combinational from bank and address |
| sclk_en | output | 1 | System-domain clock-enable strobe |
| tclk_en | output | 1 | Timer-domain clock-enable strobe |

## Verification
Read data must be valid in the cycle that the address is presented. Each strobe is due exactly one full period after the previous one, with the period length fixed by the setting in force at the preceding terminal count. The bench changes settings at the falling edge where a strobe is seen, or a known number of cycles into a period. Before any further strobe can occur, it queues the gap length each coming strobe must show. A monitor counts the oscillator cycles between strobes and compares each gap with the next queued value, so an early, late, missing or extra strobe is detected.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  typedef struct packed {
    logic byp;   // skip the halving stage
    logic pre;   // add the divide-by-16 stage
  } div_mode_t;

  localparam div_mode_t MODE_RESET = '{byp: 1'b0, pre: 1'b0};

  // Oscillator cycles per strobe for a given mode.
  function automatic int unsigned div_ratio(div_mode_t m, int unsigned pre_shift);
    int unsigned r;
    r = m.byp ? 1 : 2;
    if (m.pre) r = r << pre_shift;
    return r;
  endfunction

endpackage

// File: rtl/sclk_ctrl_reg.sv
module sclk_ctrl_reg
  import sclk_pkg::*;
#(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [BANK_W-1:0] CTRL_BANK = 'hF,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stop_rcv,
  input  logic              stat,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_hit,
  output div_mode_t         mode_q,
  output div_mode_t         mode_d
);

  logic sel;
  logic unused_wbits;

  assign sel          = (bank == CTRL_BANK) && (addr == CTRL_ADDR);
  assign wr_hit       = wr && sel;
  assign unused_wbits = ^wdata[DATA_W-1:2];

  always_comb begin
    mode_d = mode_q;
    if (wr_hit) begin
      mode_d.byp = wdata[1];
      mode_d.pre = wdata[0];
    end
    if (stop_rcv) mode_d.pre = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RESET;
    else        mode_q <= mode_d;
  end

  always_comb begin
    rdata = '0;
    if (sel) rdata[DATA_W-1] = stat;
  end

endmodule

// File: rtl/sclk_div_core.sv
module sclk_div_core
  import sclk_pkg::*;
#(
  parameter int unsigned PRE_SHIFT = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  div_mode_t mode_next,
  output logic      period_end,
  output div_mode_t mode_act
);

  localparam int unsigned CNT_W = PRE_SHIFT + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last       = CNT_W'(div_ratio(mode_act, PRE_SHIFT) - 1);
  assign period_end = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      mode_act <= MODE_RESET;
    end else if (period_end) begin
      cnt      <= '0;
      mode_act <= mode_next;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import sclk_pkg::*;
#(
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [BANK_W-1:0] CTRL_BANK = 'hF,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0B,
  parameter int unsigned PRE_SHIFT = 4
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              stop_rcv,
  input  logic [BANK_W-1:0] reg_bank,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              stat_in,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sclk_en,
  output logic              tclk_en
);

  div_mode_t cfg_q;
  div_mode_t cfg_d;
  div_mode_t act_q;
  logic      wr_hit;
  logic      period_end;

  sclk_ctrl_reg #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_BANK(CTRL_BANK), .CTRL_ADDR(CTRL_ADDR)
  ) u_reg (
    .clk(osc_clk), .rst_n(rst_n),
    .bank(reg_bank), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .stop_rcv(stop_rcv), .stat(stat_in), .rdata(reg_rdata),
    .wr_hit(wr_hit), .mode_q(cfg_q), .mode_d(cfg_d)
  );

  sclk_div_core #(.PRE_SHIFT(PRE_SHIFT)) u_div (
    .clk(osc_clk), .rst_n(rst_n),
    .mode_next(cfg_d), .period_end(period_end), .mode_act(act_q)
  );

  assign sclk_en = period_end;
  assign tclk_en = period_end;

endmodule

// File: rtl/sclk_prescaler_chk.sv
module sclk_prescaler_chk
  import sclk_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PRE_SHIFT = 4
) (
  input logic              osc_clk,
  input logic              rst_n,
  input logic              stop_rcv,
  input logic              wr_hit,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              sclk_en,
  input logic              tclk_en,
  input logic              period_end,
  input div_mode_t         cfg_q,
  input div_mode_t         act_q
);

  localparam int unsigned GAP_W = PRE_SHIFT + 3;
  localparam int unsigned MAXR  = 1 << (PRE_SHIFT + 1);

  logic [GAP_W-1:0] since;
  logic [GAP_W-1:0] gap;
  logic             gap_legal;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n)       since <= '0;
    else if (sclk_en) since <= '0;
    else              since <= since + 1'b1;
  end

  assign gap       = since + 1'b1;
  assign gap_legal = (int'(gap) == 1) || (int'(gap) == 2) ||
                     (int'(gap) == (1 << PRE_SHIFT)) || (int'(gap) == MAXR);

  // R8: both strobes are the same signal in every cycle
  a_r8_twin_strobes: assert property (@(posedge osc_clk) disable iff (!rst_n)
    tclk_en == sclk_en);

  // R4: strobe gaps are always whole periods of a legal ratio
  a_r4_whole_period: assert property (@(posedge osc_clk) disable iff (!rst_n)
    sclk_en |-> gap_legal);

  // R4: no period runs longer than the largest ratio
  a_r4_gap_bound: assert property (@(posedge osc_clk) disable iff (!rst_n)
    int'(since) < MAXR);

  // R4: the active mode only changes at a terminal count
  a_r4_hold_mid_period: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !period_end |=> $stable(act_q));

  // R5: stop recovery clears the extra divider select
  a_r5_stop_clears_pre: assert property (@(posedge osc_clk) disable iff (!rst_n)
    stop_rcv |=> !cfg_q.pre);

  // R5: stop recovery keeps the halving-skip select
  a_r5_stop_keeps_byp: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (stop_rcv && !wr_hit) |=> $stable(cfg_q.byp));

  // R7: without a decoded write or stop pulse the settings stay put
  a_r7_ignore_other: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (!wr_hit && !stop_rcv) |=> $stable(cfg_q));

  // R6: low read bits are always zero
  a_r6_low_bits_zero: assert property (@(posedge osc_clk) disable iff (!rst_n)
    reg_rdata[DATA_W-2:0] == '0);

endmodule

bind sclk_prescaler sclk_prescaler_chk #(
  .DATA_W(DATA_W), .PRE_SHIFT(PRE_SHIFT)
) u_chk (
  .osc_clk(osc_clk), .rst_n(rst_n), .stop_rcv(stop_rcv), .wr_hit(wr_hit),
  .reg_rdata(reg_rdata), .sclk_en(sclk_en), .tclk_en(tclk_en),
  .period_end(period_end), .cfg_q(cfg_q), .act_q(act_q)
);

// File: tb/sclk_prescaler_tb.sv
module sclk_prescaler_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    int    gap;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_rcv = 1'b0;
  logic [3:0] reg_bank = '0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       stat_in = 1'b0;
  logic [7:0] reg_rdata;
  logic       sclk_en;
  logic       tclk_en;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  bit   done     = 1'b0;
  bit   reported = 1'b0;
  exp_t exp_q[$];

  sclk_prescaler u_dut (
    .osc_clk(clk), .rst_n(rst_n), .stop_rcv(stop_rcv),
    .reg_bank(reg_bank), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .stat_in(stat_in), .reg_rdata(reg_rdata),
    .sclk_en(sclk_en), .tclk_en(tclk_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    end
  endtask

  // Monitor: measure strobe gaps and compare with the queue.
  initial begin
    bit first = 1'b1;
    int last  = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        first = 1'b1;
      end else if (!done && sclk_en) begin
        check(tclk_en == sclk_en, "R8", int'(tclk_en), int'(sclk_en));
        if (first) begin
          first = 1'b0;
          last  = cyc;
        end else begin
          int   g;
          exp_t e;
          g    = cyc - last;
          last = cyc;
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected strobe", g, 0);
          end else begin
            e = exp_q.pop_front();
            check(g == e.gap, e.req, g, e.gap);
          end
        end
      end
    end
  end

  // Driver helpers. All are entered and left at a falling edge.
  task automatic push(int r, int n, string req);
    for (int i = 0; i < n; i++) exp_q.push_back('{gap: r, req: req});
  endtask

  task automatic tick();
    @(negedge clk);
    reg_wr   = 1'b0;
    stop_rcv = 1'b0;
  endtask

  task automatic wait_strobes(int n);
    int k = 0;
    while (k < n) begin
      tick();
      if (sclk_en) k++;
    end
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write_reg(logic [3:0] b, logic [7:0] a, logic [7:0] d);
    reg_bank  = b;
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
  endtask

  task automatic read_check(logic [3:0] b, logic [7:0] a, logic s, logic [7:0] expv);
    reg_bank = b;
    reg_addr = a;
    stat_in  = s;
    #1;
    check(reg_rdata == expv, "R6", int'(reg_rdata), int'(expv));
  endtask

  // Stimulus
  initial begin
    wait_cycles(2);
    check(!sclk_en && !tclk_en, "R1 strobe in reset", int'(sclk_en), 0);
    // R6: reads are combinational
    read_check(4'hF, 8'h0B, 1'b1, 8'h80);
    read_check(4'hF, 8'h0B, 1'b0, 8'h00);
    read_check(4'hE, 8'h0B, 1'b1, 8'h00);
    read_check(4'hF, 8'h0C, 1'b1, 8'h00);
    stat_in = 1'b0;
    tick();
    rst_n = 1'b1;

    // R1: reset default is halving only
    wait_strobes(1);
    push(2, 3, "R1");
    wait_strobes(3);

    // R2: skip halving
    write_reg(4'hF, 8'h0B, 8'h02);
    push(1, 4, "R2");
    wait_strobes(4);

    // R3: divide-by-16 on top of bypass, then on top of halving
    write_reg(4'hF, 8'h0B, 8'h03);
    push(16, 2, "R3");
    wait_strobes(2);
    write_reg(4'hF, 8'h0B, 8'h01);
    push(32, 2, "R3");
    wait_strobes(2);

    // R4: mid-period write lets the current period finish
    push(32, 1, "R4");
    push(2, 3, "R4");
    wait_cycles(5);
    write_reg(4'hF, 8'h0B, 8'h00);
    wait_strobes(4);

    // R7: writes to other bank or address are ignored
    write_reg(4'hE, 8'h0B, 8'h02);
    push(2, 2, "R7");
    wait_strobes(2);
    write_reg(4'hF, 8'h0C, 8'h03);
    push(2, 2, "R7");
    wait_strobes(2);

    // R5: stop recovery at a terminal count keeps bypass, drops prescaler
    write_reg(4'hF, 8'h0B, 8'h03);
    push(16, 1, "R5");
    wait_strobes(1);
    stop_rcv = 1'b1;
    push(1, 3, "R5");
    wait_strobes(3);

    // R5: stop recovery mid-period waits for the terminal count
    write_reg(4'hF, 8'h0B, 8'h01);
    push(32, 1, "R5");
    push(2, 2, "R5");
    wait_cycles(3);
    stop_rcv = 1'b1;
    wait_strobes(3);

    // R5: stop pulse together with a write leaves bit 0 clear
    write_reg(4'hF, 8'h0B, 8'h03);
    stop_rcv = 1'b1;
    push(1, 2, "R5");
    wait_strobes(2);

    // R1: full reset returns bypass to 0
    check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
    rst_n = 1'b0;
    wait_cycles(3);
    check(!sclk_en && !tclk_en, "R1 strobe in reset", int'(sclk_en), 0);
    rst_n = 1'b1;
    wait_strobes(1);
    push(2, 3, "R1");
    wait_strobes(3);

    done = 1'b1;
    check(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
    summary();
    $finish;
  end

  // Watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      check(1'b0, "R4 watchdog expired", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

endmodule